// File: doc/BRIEF.md
# Configurable Registered Fan-out Buffer

This block is a wide clocked register bank placed between a memory controller and a row of memory devices. It takes a 25-bit input word on every rising clock edge and drives a 28-bit output bus. Two configuration inputs are wired to fixed levels for the life of the system, and they choose how input bits map to output positions. In the wide mode the block is a plain 25-bit one-to-one register. In the split mode the block registers 14 bits and drives each of them onto two output positions, so one device can feed twice as many loads.

In the split mode a second configuration input picks which 14 of the 25 inputs are used. Bank A uses the low inputs and bank B uses the high inputs. Two active-low chip selects let the controller freeze the outputs when no device is addressed, which saves switching power. An active-low reset clears the register at once and forces every output low.

Top module: `regFanoutBuf`

## Requirements
- R1: With cfgSplit low (wide mode), qOut[24:0] equals the dIn value captured at the last capturing rising clock edge.
- R2: With cfgSplit low, the three spare positions qOut[27:25] stay low under any input.
- R3: With cfgSplit high and cfgBankSel low, the block captures dIn[13:0], and both qOut[13:0] and qOut[27:14] equal that value.
- R4: With cfgSplit high and cfgBankSel high, the block captures dIn[24:11] (input 11+i feeds copy bit i), and both qOut[13:0] and qOut[27:14] equal that value.
- R5: A rising edge captures new data when at least one bit of csN is low, including when exactly one of the two is low.
- R6: A rising edge with csN equal to 2'b11 leaves qOut unchanged, whatever dIn carries.
- R7: Taking rstN low clears the register and drives qOut to all zeros at once, without waiting for a clock edge.
- R8: After rstN goes high, the first rising edge with a chip select low captures data normally.
- R9: cfgSplit and cfgBankSel are static. They may change only while rstN is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgSplit | input | 1 | Mode strap: 0 selects 25-bit one-to-one, 1 selects 14-bit one-to-two |
| cfgBankSel | input | 1 | Input subset strap for split mode: 0 selects bank A, 1 selects bank B |
| csN | input | 2 | Active-low chip selects; both high holds the outputs |
| dIn | input | 25 | Input data word |
| qOut | output | 28 | Registered output bus |

## Verification
Data and chip selects take effect on the first rising edge after they are driven, so each output is due one edge later. The bench drives on a falling edge and checks on the next falling edge, after exactly one rising edge has passed. Reset is the one result with no latency. The bench asserts it between edges and checks the outputs a nanosecond later, before any rising edge can occur. A hold check drives new data with both selects high and compares against the word held from the previous capture, across two edges.

// File: rtl/regFanoutPkg.sv
package regFanoutPkg;

  localparam int DATA_W  = 25;
  localparam int SPLIT_W = 14;
  localparam int CS_W    = 2;

  typedef struct packed {
    logic capture;
    logic split;
    logic bankB;
  } fanCtlT;

  // Lookup from copy bit index to input index, for either bank.
  function automatic int mapIdx(input logic bankB, input int bitIdx,
                                input int dataW, input int splitW);
    int base;
    base = bankB ? (dataW - splitW) : 0;
    return base + bitIdx;
  endfunction

endpackage

// File: rtl/regFanoutCtl.sv
module regFanoutCtl
  import regFanoutPkg::*;
#(
  parameter int CS_N = CS_W
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cfgSplit,
  input  logic            cfgBankSel,
  input  logic [CS_N-1:0] csN,
  output fanCtlT          ctl
);

  localparam logic [CS_N-1:0] ALL_IDLE = '1;

  logic anySel;

  always_comb begin
    anySel      = (csN != ALL_IDLE);
    ctl.capture = anySel;
    ctl.split   = cfgSplit;
    ctl.bankB   = cfgSplit & cfgBankSel;
  end

  AST_CFG_STATIC: assert property (@(posedge clk) disable iff (!rstN)
    $stable({cfgSplit, cfgBankSel})); // R9

endmodule

// File: rtl/regFanoutDp.sv
module regFanoutDp
  import regFanoutPkg::*;
#(
  parameter int DW = DATA_W,
  parameter int SW = SPLIT_W
) (
  input  logic            clk,
  input  logic            rstN,
  input  fanCtlT          ctl,
  input  logic [DW-1:0]   dIn,
  output logic [2*SW-1:0] qOut
);

  localparam int OW    = 2 * SW;
  localparam int SPARE = OW - DW;

  logic [SW-1:0] pickA;
  logic [SW-1:0] pickB;
  logic [SW-1:0] pick;
  logic [OW-1:0] nextWord;
  logic [OW-1:0] qReg;

  for (genvar i = 0; i < SW; i++) begin : gMap
    localparam int IA = mapIdx(1'b0, i, DW, SW);
    localparam int IB = mapIdx(1'b1, i, DW, SW);
    assign pickA[i] = dIn[IA];
    assign pickB[i] = dIn[IB];
  end

  always_comb begin
    pick = ctl.bankB ? pickB : pickA;
    if (ctl.split) nextWord = {pick, pick};
    else           nextWord = {{SPARE{1'b0}}, dIn};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            qReg <= '0;
    else if (ctl.capture) qReg <= nextWord;
  end

  assign qOut = qReg;

  AST_SPARE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.split |-> (qOut[OW-1:DW] == '0)); // R2
  AST_DUAL_COPY: assert property (@(posedge clk) disable iff (!rstN)
    ctl.split |-> (qOut[OW-1:SW] == qOut[SW-1:0])); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.capture |=> $stable(qOut)); // R6
  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (qOut == '0)); // R7

endmodule

// File: rtl/regFanoutBuf.sv
module regFanoutBuf
  import regFanoutPkg::*;
#(
  parameter int DW   = DATA_W,
  parameter int SW   = SPLIT_W,
  parameter int CS_N = CS_W
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cfgSplit,
  input  logic            cfgBankSel,
  input  logic [CS_N-1:0] csN,
  input  logic [DW-1:0]   dIn,
  output logic [2*SW-1:0] qOut
);

  fanCtlT ctl;

  regFanoutCtl #(.CS_N(CS_N)) uCtl (
    .clk        (clk),
    .rstN       (rstN),
    .cfgSplit   (cfgSplit),
    .cfgBankSel (cfgBankSel),
    .csN        (csN),
    .ctl        (ctl)
  );

  regFanoutDp #(.DW(DW), .SW(SW)) uDp (
    .clk  (clk),
    .rstN (rstN),
    .ctl  (ctl),
    .dIn  (dIn),
    .qOut (qOut)
  );

endmodule

// File: tb/sim_regFanoutBuf.sv
module sim_regFanoutBuf;

  logic        clk = 1'b0;
  logic        rstN;
  logic        cfgSplit;
  logic        cfgBankSel;
  logic [1:0]  csN;
  logic [24:0] dIn;
  logic [27:0] qOut;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  always #4 clk = ~clk;

  regFanoutBuf u0 (
    .clk(clk), .rstN(rstN), .cfgSplit(cfgSplit), .cfgBankSel(cfgBankSel),
    .csN(csN), .dIn(dIn), .qOut(qOut)
  );

  function automatic logic [27:0] model(input logic split, input logic bankB,
                                        input logic [24:0] d);
    logic [13:0] b;
    if (!split) return {3'b000, d};
    b = bankB ? d[24:11] : d[13:0];
    return {b, b};
  endfunction

  task automatic check(input string req, input logic [27:0] act,
                       input logic [27:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Reset, set straps while in reset, release with outputs held.
  task automatic setMode(input logic split, input logic bankB);
    @(negedge clk);
    rstN = 1'b0; csN = 2'b11;
    cfgSplit = split; cfgBankSel = bankB;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  // Drive at a falling edge, check one rising edge later.
  task automatic capture(input string req, input logic [24:0] d,
                         input logic [1:0] cs, input logic [27:0] exp);
    @(negedge clk);
    dIn = d; csN = cs;
    @(negedge clk);
    check(req, qOut, exp);
  endtask

  task automatic testReset();
    #1 check("R7 initial reset", qOut, 28'h0);
  endtask

  task automatic testWide();
    logic [24:0] pats [3] = '{25'h1FFFFFF, 25'h0A5A5A5, 25'h1555555};
    setMode(1'b0, 1'b0);
    foreach (pats[i]) begin
      capture("R1 wide capture", pats[i], 2'b00, model(1'b0, 1'b0, pats[i]));
      check("R2 spare low", {25'h0, qOut[27:25]}, 28'h0);
    end
  endtask

  task automatic testSplitA();
    logic [24:0] pats [3] = '{25'h1FFC000, 25'h0003FFF, 25'h0AB1234};
    setMode(1'b1, 1'b0);
    foreach (pats[i])
      capture("R3 bank A", pats[i], 2'b00, model(1'b1, 1'b0, pats[i]));
  endtask

  task automatic testSplitB();
    logic [24:0] pats [3] = '{25'h1FFF800, 25'h00007FF, 25'h1234ABC};
    setMode(1'b1, 1'b1);
    foreach (pats[i])
      capture("R4 bank B", pats[i], 2'b00, model(1'b1, 1'b1, pats[i]));
  endtask

  task automatic testSelects();
    logic [27:0] held;
    setMode(1'b0, 1'b0);
    capture("R5 cs0 low", 25'h0123456, 2'b10, model(1'b0, 1'b0, 25'h0123456));
    capture("R5 cs1 low", 25'h1654321, 2'b01, model(1'b0, 1'b0, 25'h1654321));
    held = qOut;
    capture("R6 hold", 25'h0F0F0F0, 2'b11, held);
    capture("R6 hold again", 25'h1FFFFFF, 2'b11, held);
  endtask

  task automatic testAsyncReset();
    setMode(1'b0, 1'b0);
    capture("R1 before reset", 25'h1ABCDEF, 2'b00, model(1'b0, 1'b0, 25'h1ABCDEF));
    @(posedge clk);
    #2 rstN = 1'b0;
    #1 check("R7 async clear", qOut, 28'h0);
    @(negedge clk);
    dIn = 25'h0FEDCBA; csN = 2'b00;
    @(negedge clk);
    check("R7 held in reset", qOut, 28'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R8 first edge after release", qOut, model(1'b0, 1'b0, 25'h0FEDCBA));
  endtask

  initial begin
    rstN = 1'b0; cfgSplit = 1'b0; cfgBankSel = 1'b0;
    csN = 2'b11; dIn = '0;
    testReset();
    testWide();
    testSplitA();
    testSplitB();
    testSelects();
    testAsyncReset();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      done = 1;
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule